// File: doc/BRIEF.md
# Two-Register Serial Port

A bus-attached asynchronous serial port exposed as two 32-bit words. One word is a shared data port: a write to it launches one character on the serial output, and a read returns the byte most recently taken from the serial input. The other word is a divisor that sets the bit rate. Nothing reports status. Software learns of events only through two one-cycle interrupt pulses: one when a transmitted character has fully left the line, and one when a received character has been stored.

Frames are 8N1. The line idles high. A frame is a low start bit, eight data bits sent least-significant bit first, and a high stop bit. Each bit lasts sixteen ticks of a prescaler, and the prescaler fires once every divisor clocks. The receiver synchronises its input, then confirms a start bit half a bit period after the falling edge and samples each later bit at its centre. A divisor of zero keeps both directions idle.

Top module: `mmio_uart`

## Requirements
- R1: After reset, both registers read as zero, `ser_tx` is high and both interrupt outputs are low.
- R2: The register index is `bus_addr[ADDR_W-1:2]`. Index 0 is the data port and index 1 is the divisor. A write to index 1 stores all 32 bits, and reads of it return the value last written. `bus_rdata` is zero whenever `bus_rd` is low.
- R3: A write to an index other than 0 or 1 changes no register, and a read of such an index returns zero.
- R4: With a non-zero divisor D and the transmitter idle, a write to index 0 sends `bus_wdata[7:0]` as start (0), data bits 0 to 7, stop (1). Each bit lasts exactly 16×D clocks, and bits 31:8 of the written word are ignored. The line is high whenever no frame is in progress.
- R5: `irq_tx` is high for exactly one cycle. It rises on the clock edge 160×D edges after the edge that accepted the write, which is the edge where the stop bit ends.
- R6: A write to index 0 while a frame is being sent is ignored: no second frame follows.
- R7: While the divisor is zero, a write to index 0 starts no frame, and the receiver ignores activity on `ser_rx`.
- R8: When a frame with a high stop bit is received, its byte is loaded into the data port and `irq_rx` is high for one cycle on the same edge. A read of index 0 then returns the byte zero-extended to 32 bits.
- R9: A low pulse on `ser_rx` that has ended before half a bit period is rejected as a false start. The data port is not updated and no interrupt is raised.
- R10: A frame whose stop bit samples low is discarded: no update and no `irq_rx`. The receiver then waits for the line to go high before it looks for a new start bit, and a good frame after that is received normally.
- R11: A write to index 0 does not change the value read back from index 0, and reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address and strobe |
| ser_rx | input | 1 | Serial input, asynchronous |
| ser_tx | output | 1 | Serial output, registered |
| irq_rx | output | 1 | One-cycle pulse when a byte is stored |
| irq_tx | output | 1 | One-cycle pulse when a frame completes |

## Verification
The bound checker watches every cycle for several properties. Both interrupts must be single-cycle pulses. The transmit line must be high whenever the transmitter is idle. The data port may change only together with a receive interrupt. A divisor write must store the written word, unmapped reads must return zero, and a write with a zero divisor must start nothing. Other behaviour can only be shown by the bench's scenarios, because it depends on exact frame timing or on whole frames. This covers the bit order and bit length on the line, the exact edge of the transmit interrupt, the rejection of a busy write, of a short glitch and of a frame with a bad stop bit, and the recovery after that bad frame.

// File: rtl/mmio_uart_pkg.sv
`timescale 1ns/1ps
package mmio_uart_pkg;
  localparam int unsigned OVS   = 16;
  localparam int unsigned OVS_W = $clog2(OVS);
  localparam int unsigned HALF  = OVS / 2;

  localparam int unsigned REG_DATA = 0;
  localparam int unsigned REG_DIV  = 1;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/mmio_uart_sync.sv
`timescale 1ns/1ps
module mmio_uart_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mmio_uart_baud.sv
`timescale 1ns/1ps
module mmio_uart_baud #(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             run,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             div_nz;

  assign div_nz = (div != '0);
  // >= guards against the divisor shrinking below the running count
  assign tick   = run && div_nz && (cnt_q >= div - DIV_W'(1));

  always_comb begin
    if (restart || !run || !div_nz || tick) cnt_d = '0;
    else                                    cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mmio_uart_tx.sv
`timescale 1ns/1ps
module mmio_uart_tx
  import mmio_uart_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int DIV_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              start,
  input  logic [CHAR_W-1:0] char_in,
  output logic              line,
  output logic              busy,
  output logic              done
);
  localparam int BIT_W = $clog2(CHAR_W);

  tx_state_e         st_q, st_d;
  logic [OVS_W-1:0]  sub_q, sub_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic              line_q, line_d;
  logic              tick, last_sub, dp_en;

  assign busy = (st_q != TX_IDLE);

  mmio_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .div     (div),
    .run     (busy),
    .restart (start),
    .tick    (tick)
  );

  assign last_sub = tick && (sub_q == OVS_W'(OVS - 1));
  assign dp_en    = start || tick;

  always_comb begin
    st_d   = st_q;
    sub_d  = sub_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    line_d = line_q;
    unique case (st_q)
      TX_IDLE: begin
        if (start) begin
          st_d   = TX_START;
          sh_d   = char_in;
          sub_d  = '0;
          line_d = 1'b0;
        end
      end
      TX_START: begin
        if (tick) sub_d = sub_q + OVS_W'(1);
        if (last_sub) begin
          st_d   = TX_DATA;
          bit_d  = '0;
          line_d = sh_q[0];
        end
      end
      TX_DATA: begin
        if (tick) sub_d = sub_q + OVS_W'(1);
        if (last_sub) begin
          if (bit_q == BIT_W'(CHAR_W - 1)) begin
            st_d   = TX_STOP;
            line_d = 1'b1;
          end else begin
            bit_d  = bit_q + BIT_W'(1);
            sh_d   = sh_q >> 1;
            line_d = sh_q[1];
          end
        end
      end
      TX_STOP: begin
        if (tick) sub_d = sub_q + OVS_W'(1);
        if (last_sub) begin
          st_d   = TX_IDLE;
          line_d = 1'b1;
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      line_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      line_q <= line_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else if (dp_en) begin
      sub_q <= sub_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign line = line_q;
  assign done = (st_q == TX_STOP) && last_sub;
endmodule

// File: rtl/mmio_uart_rx.sv
`timescale 1ns/1ps
module mmio_uart_rx
  import mmio_uart_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int DIV_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              rx_in,
  output logic [CHAR_W-1:0] char_out,
  output logic              done
);
  localparam int BIT_W = $clog2(CHAR_W);

  rx_state_e         st_q, st_d;
  logic [OVS_W-1:0]  sub_q, sub_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic              tick, last_sub, run, restart, dp_en;

  assign run     = (st_q == RX_START) || (st_q == RX_DATA) || (st_q == RX_STOP);
  assign restart = (st_q == RX_IDLE) && !rx_in && (div != '0);

  mmio_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .div     (div),
    .run     (run),
    .restart (restart),
    .tick    (tick)
  );

  assign last_sub = tick && (sub_q == OVS_W'(OVS - 1));
  assign dp_en    = restart || tick;

  always_comb begin
    st_d  = st_q;
    sub_d = sub_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    unique case (st_q)
      RX_IDLE: begin
        if (restart) begin
          st_d  = RX_START;
          sub_d = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (sub_q == OVS_W'(HALF - 1)) begin
            sub_d = '0;
            bit_d = '0;
            st_d  = rx_in ? RX_IDLE : RX_DATA;
          end else begin
            sub_d = sub_q + OVS_W'(1);
          end
        end
      end
      RX_DATA: begin
        if (tick) sub_d = sub_q + OVS_W'(1);
        if (last_sub) begin
          sh_d = {rx_in, sh_q[CHAR_W-1:1]};
          if (bit_q == BIT_W'(CHAR_W - 1)) st_d = RX_STOP;
          else                             bit_d = bit_q + BIT_W'(1);
        end
      end
      RX_STOP: begin
        if (tick) sub_d = sub_q + OVS_W'(1);
        if (last_sub) st_d = rx_in ? RX_IDLE : RX_WAIT_HI;
      end
      RX_WAIT_HI: begin
        if (rx_in) st_d = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RX_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else if (dp_en) begin
      sub_q <= sub_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign char_out = sh_q;
  assign done     = (st_q == RX_STOP) && last_sub && rx_in;
endmodule

// File: rtl/mmio_uart.sv
`timescale 1ns/1ps
module mmio_uart
  import mmio_uart_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int CHAR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ser_rx,
  output logic              ser_tx,
  output logic              irq_rx,
  output logic              irq_tx
);
  localparam int IDX_W = ADDR_W - 2;

  logic              rst_ni;
  logic              rx_s;
  logic [IDX_W-1:0]  idx;
  logic              sel_data, sel_div;
  logic              unused_addr_lsb;
  logic [DATA_W-1:0] div_q;
  logic [CHAR_W-1:0] data_q;
  logic              irq_rx_q, irq_tx_q;
  logic              tx_start, tx_busy, tx_done;
  logic              rx_done;
  logic [CHAR_W-1:0] rx_char;

  // async assert, synchronous release
  mmio_uart_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_ni)
  );

  mmio_uart_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk   (clk),
    .rst_n (rst_ni),
    .d     (ser_rx),
    .q     (rx_s)
  );

  assign idx             = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];
  assign sel_data        = (idx == IDX_W'(REG_DATA));
  assign sel_div         = (idx == IDX_W'(REG_DIV));

  assign tx_start = bus_wr && sel_data && !tx_busy && (div_q != '0);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (bus_wr && sel_div) div_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (rx_done) data_q <= rx_char;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_rx_q <= 1'b0;
      irq_tx_q <= 1'b0;
    end else begin
      irq_rx_q <= rx_done;
      irq_tx_q <= tx_done;
    end
  end

  mmio_uart_tx #(.CHAR_W(CHAR_W), .DIV_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_ni),
    .div     (div_q),
    .start   (tx_start),
    .char_in (bus_wdata[CHAR_W-1:0]),
    .line    (ser_tx),
    .busy    (tx_busy),
    .done    (tx_done)
  );

  mmio_uart_rx #(.CHAR_W(CHAR_W), .DIV_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_ni),
    .div      (div_q),
    .rx_in    (rx_s),
    .char_out (rx_char),
    .done     (rx_done)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_data)     bus_rdata = DATA_W'(data_q);
      else if (sel_div) bus_rdata = div_q;
    end
  end

  assign irq_rx = irq_rx_q;
  assign irq_tx = irq_tx_q;
endmodule

// File: rtl/mmio_uart_chk.sv
`timescale 1ns/1ps
module mmio_uart_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ser_tx,
  input logic              irq_rx,
  input logic              irq_tx,
  input logic [DATA_W-1:0] div_q,
  input logic [CHAR_W-1:0] data_q,
  input logic              tx_busy
);
  logic [ADDR_W-1:0] idx;
  assign idx = bus_addr >> 2;

  p_irq_tx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |=> !irq_tx);

  p_irq_rx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |=> !irq_rx);

  p_idle_line_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> ser_tx);

  p_data_moves_with_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> irq_rx);

  p_div_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx == ADDR_W'(1)) |=> (div_q == $past(bus_wdata)));

  p_unmapped_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx > ADDR_W'(1)) |-> (bus_rdata == '0));

  p_zero_div_no_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx == '0 && div_q == '0 && !tx_busy) |=> (!tx_busy && ser_tx));
endmodule

bind mmio_uart mmio_uart_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .CHAR_W (CHAR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_ni),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ser_tx    (ser_tx),
  .irq_rx    (irq_rx),
  .irq_tx    (irq_tx),
  .div_q     (div_q),
  .data_q    (data_q),
  .tx_busy   (tx_busy)
);

// File: tb/mmio_uart_tb.sv
`timescale 1ns/1ps
module mmio_uart_tb;
  logic        clk;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ser_rx;
  logic        ser_tx;
  logic        irq_rx;
  logic        irq_tx;

  int total = 0;
  int bad   = 0;
  int cur_div = 0;
  int tx_irq_cnt = 0;
  int rx_irq_cnt = 0;
  logic [7:0] tx_exp_q[$];
  logic [7:0] rx_exp_q[$];

  mmio_uart u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ser_rx    (ser_rx),
    .ser_tx    (ser_tx),
    .irq_rx    (irq_rx),
    .irq_tx    (irq_tx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic read_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1;
    chk(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  task automatic send_rx(input logic [7:0] b, input bit good_stop);
    int bp;
    bp = 16 * cur_div;
    @(negedge clk);
    bus_addr = 4'h0;
    bus_rd   = 1'b1;
    ser_rx = 1'b0;
    cycles(bp);
    for (int k = 0; k < 8; k++) begin
      ser_rx = b[k];
      cycles(bp);
    end
    ser_rx = good_stop;
    cycles(bp);
    ser_rx = 1'b1;
    cycles(bp);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  // transmit monitor: decodes frames on ser_tx and checks the interrupt edge
  initial begin
    logic [7:0] exp;
    logic [7:0] got;
    int d;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (ser_tx === 1'b0) begin
        d = (cur_div > 0) ? cur_div : 1;
        if (tx_exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected frame on ser_tx", 32'd0, 32'd1);
          exp = 8'h00;
        end else begin
          exp = tx_exp_q.pop_front();
        end
        got = 8'h00;
        for (int n = 1; n <= 160 * d + 1; n++) begin
          @(negedge clk);
          if ((n % (16 * d)) == 8 * d) begin
            if (n / (16 * d) == 0)
              chk(ser_tx === 1'b0, "R4 start bit level", {31'd0, ser_tx}, 32'd0);
            else if (n / (16 * d) == 9)
              chk(ser_tx === 1'b1, "R4 stop bit level", {31'd0, ser_tx}, 32'd1);
            else
              got[n / (16 * d) - 1] = ser_tx;
          end
          if (n == 160 * d - 1)
            chk(irq_tx === 1'b0, "R5 irq_tx early", {31'd0, irq_tx}, 32'd0);
          if (n == 160 * d)
            chk(irq_tx === 1'b1, "R5 irq_tx at stop end", {31'd0, irq_tx}, 32'd1);
          if (n == 160 * d + 1)
            chk(irq_tx === 1'b0, "R5 irq_tx one cycle", {31'd0, irq_tx}, 32'd0);
        end
        chk(got === exp, "R4 transmitted byte", {24'd0, got}, {24'd0, exp});
      end
    end
  end

  // transmit interrupt counter
  initial begin
    forever begin
      @(negedge clk);
      if (irq_tx === 1'b1) tx_irq_cnt++;
    end
  end

  // receive monitor: pops the expected byte on each receive pulse
  initial begin
    logic [7:0] exp;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (irq_rx === 1'b1) begin
        rx_irq_cnt++;
        if (rx_exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected irq_rx", bus_rdata, 32'd0);
        end else begin
          exp = rx_exp_q.pop_front();
          chk(bus_rdata === {24'd0, exp}, "R8 received byte in data port", bus_rdata, {24'd0, exp});
        end
        @(negedge clk);
        chk(irq_rx === 1'b0, "R8 irq_rx one cycle", {31'd0, irq_rx}, 32'd0);
      end
    end
  end

  initial begin
    int c0;
    rst_n     = 1'b0;
    bus_addr  = 4'h0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_wdata = 32'd0;
    ser_rx    = 1'b1;
    cycles(5);
    rst_n = 1'b1;
    cycles(4);

    // R1 reset state
    chk(ser_tx === 1'b1, "R1 ser_tx high", {31'd0, ser_tx}, 32'd1);
    chk(irq_tx === 1'b0 && irq_rx === 1'b0, "R1 irqs low", {30'd0, irq_tx, irq_rx}, 32'd0);
    read_chk(4'h0, 32'd0, "R1 data port zero");
    read_chk(4'h4, 32'd0, "R1 divisor zero");

    // R7 divisor zero: nothing sent, nothing received
    c0 = tx_irq_cnt;
    bus_write(4'h0, 32'h0000_0033);
    cycles(300);
    chk(ser_tx === 1'b1, "R7 line idle with zero divisor", {31'd0, ser_tx}, 32'd1);
    chk(tx_irq_cnt == c0, "R7 no irq_tx with zero divisor", tx_irq_cnt, c0);
    cur_div = 1;
    send_rx(8'h6E, 1'b1);
    cur_div = 0;
    cycles(20);
    chk(rx_irq_cnt == 0, "R7 receiver ignores line", rx_irq_cnt, 32'd0);
    read_chk(4'h0, 32'd0, "R7 data port unchanged");

    // R2 divisor storage and read strobe
    bus_write(4'h4, 32'h1234_5678);
    read_chk(4'h4, 32'h1234_5678, "R2 divisor readback");
    read_chk(4'h5, 32'h1234_5678, "R2 index ignores low address bits");
    @(negedge clk);
    bus_rd = 1'b0;
    #1;
    chk(bus_rdata === 32'd0, "R2 rdata zero without bus_rd", bus_rdata, 32'd0);

    // R3 unmapped index
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_write(4'hC, 32'h0000_0000);
    read_chk(4'h4, 32'h1234_5678, "R3 divisor untouched by unmapped write");
    read_chk(4'h0, 32'd0, "R3 data port untouched by unmapped write");
    read_chk(4'h8, 32'd0, "R3 unmapped read zero");
    read_chk(4'hC, 32'd0, "R3 unmapped read zero high");

    // R4, R5 transmit with divisor 2, upper bits ignored
    bus_write(4'h4, 32'd2);
    cur_div = 2;
    tx_exp_q.push_back(8'h5A);
    bus_write(4'h0, 32'hABCD_EF5A);
    cycles(160 * 2 + 20);

    // R6 write during a frame is ignored
    c0 = tx_irq_cnt;
    tx_exp_q.push_back(8'hC3);
    bus_write(4'h0, 32'h0000_00C3);
    cycles(40);
    bus_write(4'h0, 32'h0000_0011);
    cycles(160 * 2 + 200);
    chk(tx_irq_cnt == c0 + 1, "R6 exactly one frame completed", tx_irq_cnt, c0 + 1);
    chk(tx_exp_q.size() == 0, "R6 expected frame consumed", tx_exp_q.size(), 32'd0);

    // R4 divisor 3, edge patterns
    bus_write(4'h4, 32'd3);
    cur_div = 3;
    tx_exp_q.push_back(8'h01);
    bus_write(4'h0, 32'h0000_0001);
    cycles(160 * 3 + 20);
    tx_exp_q.push_back(8'h80);
    bus_write(4'h0, 32'h0000_0080);
    cycles(160 * 3 + 20);

    // R8 receive
    rx_exp_q.push_back(8'hA5);
    send_rx(8'hA5, 1'b1);
    rx_exp_q.push_back(8'h3C);
    send_rx(8'h3C, 1'b1);
    chk(rx_irq_cnt == 2, "R8 two bytes received", rx_irq_cnt, 32'd2);
    read_chk(4'h0, 32'h0000_003C, "R8 zero-extended read");

    // R11 write does not alter read value; repeated reads stable
    tx_exp_q.push_back(8'h77);
    bus_write(4'h0, 32'h0000_0077);
    read_chk(4'h0, 32'h0000_003C, "R11 data port after write");
    read_chk(4'h0, 32'h0000_003C, "R11 second read unchanged");
    cycles(160 * 3 + 20);

    // R9 short glitch rejected
    @(negedge clk);
    ser_rx = 1'b0;
    cycles(3 * 3);
    ser_rx = 1'b1;
    cycles(40 * 3);
    chk(rx_irq_cnt == 2, "R9 glitch raises no irq", rx_irq_cnt, 32'd2);
    read_chk(4'h0, 32'h0000_003C, "R9 glitch leaves data port");

    // R10 bad stop bit discarded, then recovery
    send_rx(8'h99, 1'b0);
    cycles(20);
    chk(rx_irq_cnt == 2, "R10 bad frame raises no irq", rx_irq_cnt, 32'd2);
    read_chk(4'h0, 32'h0000_003C, "R10 bad frame leaves data port");
    rx_exp_q.push_back(8'h42);
    send_rx(8'h42, 1'b1);
    chk(rx_irq_cnt == 3, "R10 good frame after bad one", rx_irq_cnt, 32'd3);
    read_chk(4'h0, 32'h0000_0042, "R10 data after recovery");
    chk(rx_exp_q.size() == 0, "R8 all expected bytes seen", rx_exp_q.size(), 32'd0);

    cycles(10);
    finish_run();
  end
endmodule